// File: doc/BRIEF.md
# Alarm, Watchdog and Wakeup Controller

This block sits beside a time-of-day counter and turns three kinds of event into system control signals. The first event is a time-of-day alarm. It compares the current seconds, minutes, hours and either the day of week or the day of month against programmed values, and each field can be masked. The second is a CPU watchdog, which counts down on a prescaled tick. The third is a rising edge on an external kickstart input, such as a key press. Each event sets a sticky flag. Software routes each event either to a level interrupt output or to a fixed-length reset pulse.

A power-enable output lets the system be woken. A kickstart always turns it on, and an alarm turns it on when wakeup is enabled. Software can clear the power-enable output to shut the system down. A supply-fail input holds the reset output asserted while the supply is bad, and for a fixed settling time after it recovers. Software reaches the block through a small synchronous register port with a one-cycle registered read.

Top module: `alarm_wdog_wake`

## Requirements
- R1: The alarm registers are at addresses 0 (seconds, value bits [5:0]), 1 (minutes, bits [5:0]), 2 (hours, bits [4:0]) and 3 (day, bits [5:0]). Bit 7 of each register is a mask. A masked field always matches. When `tod_upd` is high and all four fields match, an alarm event occurs.
- R2: Bit 6 of the day register selects the compare mode. When it is 1, the day value is compared with the zero-extended `tod_dow`. When it is 0, the day value is compared with the zero-extended `tod_date`.
- R3: Address 6 returns the flags: bit 0 is alarm, bit 1 is watchdog and bit 2 is kickstart. Each flag is set by its event and stays set until a read of address 6. That read returns the old value and clears the flags, except that an event in the same cycle still sets its flag. Read data appears the cycle after `bus_rd`.
- R4: The control register is at address 5. Bits 0, 1 and 2 route the alarm, watchdog and kickstart events to reset when set, and to the interrupt when clear. `irq_out` is high while any flag routed to the interrupt is set. An event routed to reset holds `rst_out` high for RST_PULSE (4) cycles.
- R5: Writing address 4 loads the watchdog period and reloads the count. With a period P other than 0, the P-th `wd_tick` after the load raises a watchdog event, and counting then restarts from P. A period of 0 stops the watchdog.
- R6: A rising edge on `kick_in` raises a kickstart event and sets `pwr_en`. Holding `kick_in` high gives only one event.
- R7: When control bit 3 (wakeup enable) is set, an alarm event sets `pwr_en`. When it is clear, an alarm event leaves `pwr_en` unchanged.
- R8: Writing the control register sets `pwr_en` to bit 4 of the written data, so writing 0 there shuts the power off. A read of address 5 returns `pwr_en` in bit 4.
- R9: `rst_out` is high while `pwr_fail` is high. After `pwr_fail` is seen low, `rst_out` stays high for PF_HOLD (8) more cycles.
- R10: After reset, `irq_out`, `rst_out` and `pwr_en` are low, and all registers, including the flags, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tod_sec | input | 6 | Current seconds |
| tod_min | input | 6 | Current minutes |
| tod_hour | input | 5 | Current hours |
| tod_dow | input | 3 | Current day of week |
| tod_date | input | 5 | Current day of month |
| tod_upd | input | 1 | One-cycle strobe when the time has advanced |
| wd_tick | input | 1 | Watchdog count strobe |
| kick_in | input | 1 | Kickstart request, synchronous level |
| pwr_fail | input | 1 | Supply-fail indication |
| irq_out | output | 1 | Interrupt, active high |
| rst_out | output | 1 | System reset, active high |
| pwr_en | output | 1 | Power-supply enable |

## Verification
The assertions assume that `kick_in`, `pwr_fail`, `tod_upd` and `wd_tick` are synchronous to `clk`, and that software clears a flag only by reading address 6. They also assume that `pwr_fail` does not fall while an event routed to reset is in progress. The stimulus drives every input on the falling edge, so each input is stable around the rising edge that samples it. The random alarm patterns keep each time field within its calendar range. They make each field equal to the alarm value about half the time, so that matching and non-matching outcomes both occur often.

// File: rtl/awk_pkg.sv
package awk_pkg;
  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] dow;
    logic [4:0] date;
  } tod_t;

  localparam int NUM_EVT = 3;
  localparam int EV_ALM  = 0;
  localparam int EV_WD   = 1;
  localparam int EV_KICK = 2;

  localparam logic [2:0] A_PERIOD = 3'd4;
  localparam logic [2:0] A_CTRL   = 3'd5;
  localparam logic [2:0] A_FLAGS  = 3'd6;
  localparam logic [2:0] A_WDCNT  = 3'd7;

  localparam int C_WAKE = 3;
  localparam int C_PWR  = 4;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import awk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [7:0]      wdata,
  input  tod_t            now,
  input  logic            upd,
  output logic            evt,
  output logic [3:0][7:0] regs_rb
);
  logic [3:0][7:0] regs_q, regs_d;
  logic [3:0]      fld_hit;

  always_comb begin
    regs_d = regs_q;
    if (wr_en && addr[2] == 1'b0)
      regs_d[addr[1:0]] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  always_comb begin
    fld_hit[0] = regs_q[0][7] | (regs_q[0][5:0] == now.sec);
    fld_hit[1] = regs_q[1][7] | (regs_q[1][5:0] == now.min);
    fld_hit[2] = regs_q[2][7] | (regs_q[2][4:0] == now.hour);
    if (regs_q[3][6])
      fld_hit[3] = regs_q[3][7] | (regs_q[3][5:0] == {3'b000, now.dow});
    else
      fld_hit[3] = regs_q[3][7] | (regs_q[3][5:0] == {1'b0, now.date});
  end

  assign evt     = upd & (&fld_hit);
  assign regs_rb = regs_q;

  a_r1_all_masked_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && regs_q[0][7] && regs_q[1][7] && regs_q[2][7] && regs_q[3][7]) |-> evt);
  a_r1_quiet_without_upd: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> !evt);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int WD_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [WD_W-1:0] ld_val,
  input  logic            tick,
  output logic            evt,
  output logic [WD_W-1:0] cnt,
  output logic [WD_W-1:0] period
);
  logic [WD_W-1:0] cnt_q, cnt_d, per_q, per_d;
  logic            armed;

  assign armed = (per_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    evt   = 1'b0;
    if (ld) begin
      per_d = ld_val;
      cnt_d = ld_val;
    end else if (tick && armed) begin
      if (cnt_q == WD_W'(1)) begin
        evt   = 1'b1;
        cnt_d = per_q;
      end else begin
        cnt_d = cnt_q - WD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign cnt    = cnt_q;
  assign period = per_q;

  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt_q != '0 && cnt_q <= per_q));
  a_r5_stopped_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !evt);
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int PULSE = 4,
  parameter int HOLD  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic trig,
  output logic rst_out
);
  localparam int MAXC = (HOLD > PULSE) ? HOLD : PULSE;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (pwr_fail)
      cnt_d = CW'(HOLD);
    else if (trig)
      cnt_d = (cnt_q > CW'(PULSE)) ? cnt_q : CW'(PULSE);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rst_out = pwr_fail | (cnt_q != '0);

  a_r9_hold_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_fail) |-> rst_out);
  a_r4_trig_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> rst_out);
endmodule

// File: rtl/alarm_wdog_wake.sv
module alarm_wdog_wake
  import awk_pkg::*;
#(
  parameter int WD_W      = 8,
  parameter int RST_PULSE = 4,
  parameter int PF_HOLD   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [5:0] tod_sec,
  input  logic [5:0] tod_min,
  input  logic [4:0] tod_hour,
  input  logic [2:0] tod_dow,
  input  logic [4:0] tod_date,
  input  logic       tod_upd,
  input  logic       wd_tick,
  input  logic       kick_in,
  input  logic       pwr_fail,
  output logic       irq_out,
  output logic       rst_out,
  output logic       pwr_en
);
  logic [1:0]         rsync_q;
  logic               rst_ns;
  tod_t               now;
  logic [NUM_EVT-1:0] evts, flags_q, flags_d, route;
  logic [3:0]         ctrl_q, ctrl_d;
  logic               pwr_q, pwr_d, kick_q, kick_evt, alm_evt, wd_evt;
  logic               rd_clr, ctrl_wr;
  logic [7:0]         rdata_q, rdata_d;
  logic [3:0][7:0]    alm_rb;
  logic [WD_W-1:0]    wd_cnt, wd_per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  assign now = '{sec: tod_sec, min: tod_min, hour: tod_hour, dow: tod_dow, date: tod_date};

  alarm_match u_alarm (
    .clk(clk), .rst_n(rst_ns), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .now(now), .upd(tod_upd), .evt(alm_evt), .regs_rb(alm_rb)
  );

  wdog_timer #(.WD_W(WD_W)) u_wdog (
    .clk(clk), .rst_n(rst_ns), .ld(bus_wr && bus_addr == A_PERIOD),
    .ld_val(WD_W'(bus_wdata)), .tick(wd_tick), .evt(wd_evt), .cnt(wd_cnt), .period(wd_per)
  );

  assign kick_evt      = kick_in & ~kick_q;
  assign evts[EV_ALM]  = alm_evt;
  assign evts[EV_WD]   = wd_evt;
  assign evts[EV_KICK] = kick_evt;
  assign route         = ctrl_q[NUM_EVT-1:0];
  assign rd_clr        = bus_rd && bus_addr == A_FLAGS;
  assign ctrl_wr       = bus_wr && bus_addr == A_CTRL;

  rst_stretch #(.PULSE(RST_PULSE), .HOLD(PF_HOLD)) u_rst (
    .clk(clk), .rst_n(rst_ns), .pwr_fail(pwr_fail), .trig(|(evts & route)), .rst_out(rst_out)
  );

  always_comb begin
    flags_d = (rd_clr ? '0 : flags_q) | evts;
    ctrl_d  = ctrl_wr ? bus_wdata[3:0] : ctrl_q;
    pwr_d   = ctrl_wr ? bus_wdata[C_PWR] : pwr_q;
    if (kick_evt || (alm_evt && ctrl_q[C_WAKE]))
      pwr_d = 1'b1;
    rdata_d = rdata_q;
    if (bus_rd) begin
      case (bus_addr)
        A_PERIOD: rdata_d = 8'(wd_per);
        A_CTRL:   rdata_d = {3'b000, pwr_q, ctrl_q};
        A_FLAGS:  rdata_d = 8'(flags_q);
        A_WDCNT:  rdata_d = 8'(wd_cnt);
        default:  rdata_d = alm_rb[bus_addr[1:0]];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      flags_q <= '0;
      ctrl_q  <= '0;
      pwr_q   <= 1'b0;
      kick_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      flags_q <= flags_d;
      ctrl_q  <= ctrl_d;
      pwr_q   <= pwr_d;
      kick_q  <= kick_in;
      rdata_q <= rdata_d;
    end
  end

  assign irq_out   = |(flags_q & ~route);
  assign pwr_en    = pwr_q;
  assign bus_rdata = rdata_q;

  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd_clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  a_r4_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_ns)
    (flags_q == '0) |-> !irq_out);
  a_r6_kick_powers_on: assert property (@(posedge clk) disable iff (!rst_ns)
    kick_evt |=> pwr_en);
  a_r7_wake_powers_on: assert property (@(posedge clk) disable iff (!rst_ns)
    (alm_evt && ctrl_q[C_WAKE]) |=> pwr_en);
  a_r8_power_rise_cause: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(pwr_en) |-> $past(kick_evt || (alm_evt && ctrl_q[C_WAKE]) || ctrl_wr));
endmodule

// File: tb/test_alarm_wdog_wake.sv
module test_alarm_wdog_wake;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 4;
  localparam int HOLD  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [5:0] tod_sec = '0, tod_min = '0;
  logic [4:0] tod_hour = '0, tod_date = '0;
  logic [2:0] tod_dow = '0;
  logic tod_upd = 0, wd_tick = 0, kick_in = 0, pwr_fail = 0;
  logic irq_out, rst_out, pwr_en;
  int checks = 0, fails = 0;
  bit done = 0;

  alarm_wdog_wake #(.WD_W(8), .RST_PULSE(PULSE), .PF_HOLD(HOLD)) i_alarm_wdog_wake (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tod_sec(tod_sec), .tod_min(tod_min),
    .tod_hour(tod_hour), .tod_dow(tod_dow), .tod_date(tod_date), .tod_upd(tod_upd),
    .wd_tick(wd_tick), .kick_in(kick_in), .pwr_fail(pwr_fail),
    .irq_out(irq_out), .rst_out(rst_out), .pwr_en(pwr_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic time_pulse(input logic [5:0] s, input logic [5:0] m, input logic [4:0] h,
                            input logic [2:0] w, input logic [4:0] dt);
    tod_sec = s; tod_min = m; tod_hour = h; tod_dow = w; tod_date = dt; tod_upd = 1;
    @(negedge clk);
    tod_upd = 0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      wd_tick = 1; @(negedge clk); wd_tick = 0; @(negedge clk);
    end
  endtask

  task automatic count_rst(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      #1; if (rst_out) c++;
      @(negedge clk);
    end
  endtask

  function automatic bit exp_match(input logic [3:0][7:0] r, input logic [5:0] s,
      input logic [5:0] m, input logic [4:0] h, input logic [2:0] w, input logic [4:0] dt);
    bit ds;
    ds = r[3][6] ? (r[3][5:0] == {3'b0, w}) : (r[3][5:0] == {1'b0, dt});
    return (r[0][7] || r[0][5:0] == s) && (r[1][7] || r[1][5:0] == m) &&
           (r[2][7] || r[2][4:0] == h) && (r[3][7] || ds);
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [3:0][7:0] ar;
    logic [5:0] s, m;
    logic [4:0] h, dt;
    logic [2:0] w;
    bit e;
    int c, nmatch;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk(!irq_out && !rst_out && !pwr_en, "R10 outputs", {irq_out, rst_out, pwr_en}, 0);
    rd(A_FLAGS_T, d); chk(d == 0, "R10 flags", d, 0);
    rd(3'd5, d); chk(d == 0, "R10 ctrl", d, 0);
    rd(3'd0, d); chk(d == 0, "R10 alarm sec", d, 0);

    // R1 full unmasked match, date mode, routed to irq
    wr(3'd0, 8'd30); wr(3'd1, 8'd15); wr(3'd2, 8'd9); wr(3'd3, 8'd12);
    time_pulse(6'd30, 6'd15, 5'd9, 3'd2, 5'd12);
    chk(irq_out == 1, "R1 match irq", irq_out, 1);
    chk(pwr_en == 0, "R7 no wake when disabled", pwr_en, 0);
    rd(3'd6, d); chk(d == 8'd1, "R3 flag read", d, 1);
    rd(3'd6, d); chk(d == 8'd0, "R3 read clears", d, 0);
    chk(irq_out == 0, "R4 irq drops after clear", irq_out, 1'b0);
    time_pulse(6'd31, 6'd15, 5'd9, 3'd2, 5'd12);
    rd(3'd6, d); chk(d == 8'd0, "R1 seconds mismatch", d, 0);
    // R2 day-of-week mode
    wr(3'd3, 8'h45);
    time_pulse(6'd30, 6'd15, 5'd9, 3'd5, 5'd12);
    rd(3'd6, d); chk(d == 8'd1, "R2 dow match", d, 1);
    time_pulse(6'd30, 6'd15, 5'd9, 3'd4, 5'd5);
    rd(3'd6, d); chk(d == 8'd0, "R2 date ignored in dow mode", d, 0);

    // R1 R2 random patterns
    nmatch = 0;
    for (int it = 0; it < 60; it++) begin
      s = 6'($urandom % 60); m = 6'($urandom % 60); h = 5'($urandom % 24);
      w = 3'($urandom % 8); dt = 5'(1 + $urandom % 31);
      ar[0] = {($urandom % 4 == 0), 1'b0, ($urandom % 2) ? s : 6'($urandom % 60)};
      ar[1] = {($urandom % 4 == 0), 1'b0, ($urandom % 2) ? m : 6'($urandom % 60)};
      ar[2] = {($urandom % 4 == 0), 2'b0, ($urandom % 2) ? h : 5'($urandom % 24)};
      ar[3][7] = ($urandom % 4 == 0);
      ar[3][6] = $urandom % 2;
      if ($urandom % 2) ar[3][5:0] = ar[3][6] ? {3'b0, w} : {1'b0, dt};
      else              ar[3][5:0] = 6'($urandom % 32);
      for (int k = 0; k < 4; k++) wr(3'(k), ar[k]);
      time_pulse(s, m, h, w, dt);
      e = exp_match(ar, s, m, h, w, dt);
      if (e) nmatch++;
      chk(irq_out == e, "R1 random irq", irq_out, e);
      rd(3'd6, d); chk(d == {7'b0, e}, "R2 random flags", d, e);
    end
    chk(nmatch > 0 && pwr_en == 0, "R7 random no wake", pwr_en, 0);

    // R4 alarm routed to reset
    wr(3'd5, 8'h01);
    for (int k = 0; k < 4; k++) wr(3'(k), 8'h80);
    time_pulse(6'd1, 6'd2, 5'd3, 3'd4, 5'd5);
    chk(irq_out == 0, "R4 reset-routed no irq", irq_out, 0);
    count_rst(16, c); chk(c == PULSE, "R4 reset pulse width", c, PULSE);
    rd(3'd6, d); chk(d == 8'd1, "R4 flag still set", d, 1);

    // R7 wakeup alarm
    wr(3'd5, 8'h08);
    time_pulse(6'd1, 6'd2, 5'd3, 3'd4, 5'd5);
    chk(pwr_en == 1, "R7 wake powers on", pwr_en, 1);
    rd(3'd5, d); chk(d == 8'h18, "R8 ctrl readback", d, 8'h18);
    // R8 software off and on
    wr(3'd5, 8'h00);
    chk(pwr_en == 0, "R8 software off", pwr_en, 0);
    wr(3'd5, 8'h10);
    chk(pwr_en == 1, "R8 software on", pwr_en, 1);
    wr(3'd5, 8'h00);
    rd(3'd6, d);

    // R5 watchdog
    wr(3'd4, 8'd5);
    tick_n(4);
    rd(3'd6, d); chk(d == 0, "R5 no timeout before P", d, 0);
    tick_n(1);
    chk(irq_out == 1, "R5 timeout irq", irq_out, 1);
    rd(3'd6, d); chk(d == 8'd2, "R5 timeout flag", d, 2);
    tick_n(4);
    rd(3'd6, d); chk(d == 0, "R5 reload not early", d, 0);
    tick_n(1);
    rd(3'd6, d); chk(d == 8'd2, "R5 repeats", d, 2);
    tick_n(3); wr(3'd4, 8'd5); tick_n(4);
    rd(3'd6, d); chk(d == 0, "R5 write reloads", d, 0);
    wr(3'd4, 8'd0); tick_n(12);
    rd(3'd6, d); chk(d == 0, "R5 zero stops", d, 0);
    wr(3'd5, 8'h02); wr(3'd4, 8'd2); tick_n(1);
    wd_tick = 1; @(negedge clk); wd_tick = 0;
    count_rst(16, c); chk(c == PULSE, "R4 watchdog reset pulse", c, PULSE);
    chk(irq_out == 0, "R4 watchdog no irq", irq_out, 0);
    wr(3'd4, 8'd0); rd(3'd6, d);

    // R6 kickstart
    wr(3'd5, 8'h00);
    kick_in = 1; @(negedge clk);
    chk(pwr_en == 1, "R6 kick powers on", pwr_en, 1);
    chk(irq_out == 1, "R6 kick irq", irq_out, 1);
    rd(3'd6, d); chk(d == 8'd4, "R6 kick flag", d, 4);
    repeat (4) @(negedge clk);
    rd(3'd6, d); chk(d == 0, "R6 held level one event", d, 0);
    kick_in = 0; @(negedge clk);

    // R9 power fail hold
    pwr_fail = 1; @(negedge clk); #1;
    chk(rst_out == 1, "R9 held during fail", rst_out, 1);
    repeat (5) @(negedge clk);
    pwr_fail = 0;
    count_rst(20, c); chk(c == HOLD, "R9 hold after recovery", c, HOLD);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [2:0] A_FLAGS_T = 3'd6;
endmodule